// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator machine. Instructions are 12 bits wide: a 4-bit opcode and an 8-bit operand address. A 6-bit microaddress register steps through a 64-word control store. Each cycle the word at the current microaddress drives the datapath controls: four register load enables, a 4-bit ALU function, a 2-bit B-operand select, an A-operand gate, and the memory read and write strobes. Those outputs depend only on the microaddress, so they behave as Moore outputs.

Each control word also carries three sequencing fields: a condition code, an address-source bit and a 6-bit jump target. The condition code picks one of five tests: never, always, accumulator sign clear, ALU result non-zero, or start low. When the selected test is true, the microaddress loads a new value. That value is either the jump target or a dispatch address built from the opcode. When the test is false, the microaddress increments. Every opcode owns two adjacent dispatch words at {1, opcode, 0} and {1, opcode, 1}. The idle, fetch and decode states are shared, and execute steps longer than two words sit in the low part of the store.

The surrounding datapath is outside this block. It builds ALU operand A as the accumulator when the gate is high, or zero otherwise. Operand B is chosen by the select: 00 gives zero, 01 gives PC, 10 gives MDR[7:0] and 11 gives the full MDR. The function bits are {b-invert, carry-in, op1, op0}, where op 00 is AND, 01 is OR and 10 is ADD. The result feeds the accumulator, PC and MAR. The instruction register is loaded from memory in the cycle where the PC load and the MDR load are both high. Its opcode comes back on `opcode`. The accumulator sign and the ALU zero flag come back as condition inputs.

Top module: `mseq_ctrl`

## Requirements
- R1: A synchronous reset puts the sequencer in the idle state. In that state ld_pc and ld_mar are 1, bsel is 00, alu_fn is 0010 and every other output is 0, so PC and MAR are cleared.
- R2: In the idle state with start low, the outputs stay unchanged and no fetch occurs. With start high, the fetch word appears on the next cycle.
- R3: The fetch word sets mem_rd, ld_mdr, ld_pc and ld_mar, with bsel 01, gate_a 0 and alu_fn 0110 (A+B+1), so PC and MAR become PC+1. It is always followed by one decode cycle in which every output is 0.
- R4: After decode, the microaddress becomes {1, opcode, 0}, and the second word of that opcode is reached by increment. The opcodes are JMP 0, JN 1, JZ 2, LOAD 4, STORE 5, AND 8, OR 9, ADD 10 and SUB 11.
- R5: Condition codes 0 to 4 select never, always, not-sign, not-zero and not-start, and codes 5 to 7 act as never. A whole program therefore takes exactly the sum of its per-instruction cycle counts.
- R6: JN branches only when bit 11 of the accumulator is 1. A taken JN takes 4 cycles and loads PC and MAR from the operand. A JN that falls through takes 3 cycles and changes neither.
- R7: JZ branches only when the accumulator is zero. It takes 4 cycles when taken and 3 when it falls through. The zero test uses gate_a 1 and bsel 00 in the JZ step.
- R8: JMP takes 3 cycles and loads PC and MAR with the operand address.
- R9: LOAD, AND, OR, ADD and SUB take 5 cycles. Their last step loads the accumulator with bsel 11, and the function is ADD with gate 0 for LOAD, or 0000, 0001, 0010 or 1110 with gate 1 for the four ALU ops.
- R10: STORE takes 4 cycles. It loads MAR from MDR[7:0] (bsel 10), then pulses mem_wr for one cycle while MAR is reloaded from PC.
- R11: Reserved opcodes 3, 6, 7 and 12 to 15 take 3 cycles and change nothing except the PC increment from the fetch.
- R12: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Leave the idle state |
| a_sign | input | 1 | Accumulator bit 11 |
| alu_zero | input | 1 | ALU result is zero |
| opcode | input | 4 | Opcode from the instruction register |
| ld_acc | output | 1 | Accumulator load |
| ld_pc | output | 1 | PC load |
| ld_mar | output | 1 | MAR load |
| ld_mdr | output | 1 | MDR load (with IR on fetch) |
| alu_fn | output | 4 | {b-invert, carry-in, op1, op0} |
| bsel | output | 2 | ALU B-operand select |
| gate_a | output | 1 | Pass accumulator to ALU A input |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |

## Verification
Two datapath actions share one control word in this block. In the operand-access step, the memory read through MAR happens in the same cycle as MAR being reloaded with PC. The store step pairs the write strobe with that same MAR reload. The bench places operands far from the instruction stream, so a wrong ordering shows up as the wrong data in the accumulator or memory, or as a fetch of the wrong address. It judges each program by its final accumulator, the data-region memory and the exact cycle at which the final address is fetched. It does this for directed branch and opcode cases and for seeded random programs.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int UADDR_W = 6;
  localparam int OP_W    = 4;
  localparam int UDEPTH  = 1 << UADDR_W;
  localparam int FN_W    = 4;
  localparam int BSEL_W  = 2;
  localparam int CSEL_W  = 3;

  typedef logic [UADDR_W-1:0] uaddr_t;

  typedef struct packed {
    logic [CSEL_W-1:0] csel;
    logic              asel;
    uaddr_t            nxt;
    logic              ld_a;
    logic              ld_pc;
    logic              ld_mar;
    logic              ld_mdr;
    logic [FN_W-1:0]   fn;
    logic [BSEL_W-1:0] bsel;
    logic              gate_a;
    logic              rd;
    logic              wt;
  } uword_t;

  // condition codes
  localparam logic [CSEL_W-1:0] C_NEVER  = 3'd0;
  localparam logic [CSEL_W-1:0] C_ALWAYS = 3'd1;
  localparam logic [CSEL_W-1:0] C_NSIGN  = 3'd2;
  localparam logic [CSEL_W-1:0] C_NZERO  = 3'd3;
  localparam logic [CSEL_W-1:0] C_NSTART = 3'd4;

  // B-operand select
  localparam logic [BSEL_W-1:0] B_ZERO = 2'd0;
  localparam logic [BSEL_W-1:0] B_PC   = 2'd1;
  localparam logic [BSEL_W-1:0] B_MDRA = 2'd2;
  localparam logic [BSEL_W-1:0] B_MDRW = 2'd3;

  // ALU function {b-invert, carry-in, op1, op0}
  localparam logic [FN_W-1:0] FN_AND = 4'b0000;
  localparam logic [FN_W-1:0] FN_OR  = 4'b0001;
  localparam logic [FN_W-1:0] FN_ADD = 4'b0010;
  localparam logic [FN_W-1:0] FN_INC = 4'b0110;
  localparam logic [FN_W-1:0] FN_SUB = 4'b1110;

  // opcodes
  localparam logic [OP_W-1:0] OP_JMP   = 4'd0;
  localparam logic [OP_W-1:0] OP_JN    = 4'd1;
  localparam logic [OP_W-1:0] OP_JZ    = 4'd2;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'd4;
  localparam logic [OP_W-1:0] OP_STORE = 4'd5;
  localparam logic [OP_W-1:0] OP_AND   = 4'd8;
  localparam logic [OP_W-1:0] OP_OR    = 4'd9;
  localparam logic [OP_W-1:0] OP_ADD   = 4'd10;
  localparam logic [OP_W-1:0] OP_SUB   = 4'd11;

  // shared microaddresses
  localparam uaddr_t UA_STOP   = uaddr_t'(0);
  localparam uaddr_t UA_FETCH  = uaddr_t'(1);
  localparam uaddr_t UA_DECODE = uaddr_t'(2);
  localparam uaddr_t UA_X_LOAD = uaddr_t'(3);
  localparam uaddr_t UA_X_ALU  = uaddr_t'(4);

  // two words per opcode in the upper half of the store
  function automatic uaddr_t dispatch_addr(input logic [OP_W-1:0] op);
    return {1'b1, op, 1'b0};
  endfunction

  function automatic uword_t w_goto(input uaddr_t tgt);
    uword_t w;
    w = '0;
    w.csel = C_ALWAYS;
    w.nxt  = tgt;
    return w;
  endfunction

  function automatic uword_t w_take();
    uword_t w;
    w = w_goto(UA_FETCH);
    w.ld_pc  = 1'b1;
    w.ld_mar = 1'b1;
    w.bsel   = B_MDRA;
    w.fn     = FN_ADD;
    return w;
  endfunction

  function automatic uword_t w_ea();
    uword_t w;
    w = '0;
    w.csel   = C_NEVER;
    w.ld_mar = 1'b1;
    w.bsel   = B_MDRA;
    w.fn     = FN_ADD;
    return w;
  endfunction

  function automatic uword_t w_opnd(input uaddr_t exec);
    uword_t w;
    w = w_goto(exec);
    w.rd     = 1'b1;
    w.ld_mdr = 1'b1;
    w.ld_mar = 1'b1;
    w.bsel   = B_PC;
    w.fn     = FN_ADD;
    return w;
  endfunction

  function automatic uword_t w_exec(input logic [FN_W-1:0] fn, input logic gate);
    uword_t w;
    w = w_goto(UA_FETCH);
    w.ld_a   = 1'b1;
    w.bsel   = B_MDRW;
    w.fn     = fn;
    w.gate_a = gate;
    return w;
  endfunction

  // control store contents, computed per microaddress
  function automatic uword_t uword_at(input uaddr_t a);
    uword_t w;
    logic [OP_W-1:0] op;
    logic second;
    op     = a[OP_W:1];
    second = a[0];
    w      = w_goto(UA_STOP);
    if (a == UA_STOP) begin
      w.csel   = C_NSTART;
      w.ld_pc  = 1'b1;
      w.ld_mar = 1'b1;
      w.bsel   = B_ZERO;
      w.fn     = FN_ADD;
    end else if (a == UA_FETCH) begin
      w        = '0;
      w.csel   = C_NEVER;
      w.ld_pc  = 1'b1;
      w.ld_mar = 1'b1;
      w.ld_mdr = 1'b1;
      w.rd     = 1'b1;
      w.bsel   = B_PC;
      w.fn     = FN_INC;
    end else if (a == UA_DECODE) begin
      w.asel = 1'b1;
    end else if (a == UA_X_LOAD) begin
      w = w_exec(FN_ADD, 1'b0);
    end else if (a == UA_X_ALU)              w = w_exec(FN_AND, 1'b1);
    else if (a == (UA_X_ALU | uaddr_t'(1)))  w = w_exec(FN_OR,  1'b1);
    else if (a == (UA_X_ALU | uaddr_t'(2)))  w = w_exec(FN_ADD, 1'b1);
    else if (a == (UA_X_ALU | uaddr_t'(3)))  w = w_exec(FN_SUB, 1'b1);
    else if (a[UADDR_W-1]) begin
      case (op)
        OP_JMP:   if (!second) w = w_take();
        OP_JN:    if (!second) begin
                    w = w_goto(UA_FETCH);
                    w.csel = C_NSIGN;
                  end else w = w_take();
        OP_JZ:    if (!second) begin
                    w = w_goto(UA_FETCH);
                    w.csel   = C_NZERO;
                    w.gate_a = 1'b1;
                    w.bsel   = B_ZERO;
                    w.fn     = FN_ADD;
                  end else w = w_take();
        OP_LOAD:  w = second ? w_opnd(UA_X_LOAD) : w_ea();
        OP_STORE: if (!second) w = w_ea();
                  else begin
                    w = w_goto(UA_FETCH);
                    w.wt     = 1'b1;
                    w.ld_mar = 1'b1;
                    w.bsel   = B_PC;
                    w.fn     = FN_ADD;
                  end
        OP_AND, OP_OR, OP_ADD, OP_SUB:
                  w = second ? w_opnd(UA_X_ALU | uaddr_t'(op[1:0])) : w_ea();
        default:  if (!second) w = w_goto(UA_FETCH);
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/mseq_store.sv
module mseq_store
  import mseq_pkg::*;
(
  input  uaddr_t addr,
  output uword_t word
);
  uword_t rom [UDEPTH];

  for (genvar i = 0; i < UDEPTH; i++) begin : g_rom
    assign rom[i] = uword_at(uaddr_t'(i));
  end

  assign word = rom[addr];
endmodule

// File: rtl/mseq_cond_mux.sv
module mseq_cond_mux
  import mseq_pkg::*;
(
  input  logic [CSEL_W-1:0] csel,
  input  logic              a_sign,
  input  logic              alu_zero,
  input  logic              start,
  output logic              ld_en
);
  always_comb begin
    case (csel)
      C_NEVER:  ld_en = 1'b0;
      C_ALWAYS: ld_en = 1'b1;
      C_NSIGN:  ld_en = ~a_sign;
      C_NZERO:  ld_en = ~alu_zero;
      C_NSTART: ld_en = ~start;
      default:  ld_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
(
  input  uaddr_t          q,
  input  logic            ld_en,
  input  logic            asel,
  input  uaddr_t          nxt,
  input  logic [OP_W-1:0] opcode,
  output uaddr_t          q_nxt
);
  uaddr_t jump_tgt;

  assign jump_tgt = asel ? dispatch_addr(opcode) : nxt;
  assign q_nxt    = ld_en ? jump_tgt : q + uaddr_t'(1);
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              a_sign,
  input  logic              alu_zero,
  input  logic [OP_W-1:0]   opcode,
  output logic              ld_acc,
  output logic              ld_pc,
  output logic              ld_mar,
  output logic              ld_mdr,
  output logic [FN_W-1:0]   alu_fn,
  output logic [BSEL_W-1:0] bsel,
  output logic              gate_a,
  output logic              mem_rd,
  output logic              mem_wr
);
  uaddr_t uaddr;
  uaddr_t uaddr_nxt;
  uword_t uw;
  logic   ld_en;

  always_ff @(posedge clk) begin
    if (rst) uaddr <= UA_STOP;
    else     uaddr <= uaddr_nxt;
  end

  mseq_store u_store (
    .addr (uaddr),
    .word (uw)
  );

  mseq_cond_mux u_cond (
    .csel     (uw.csel),
    .a_sign   (a_sign),
    .alu_zero (alu_zero),
    .start    (start),
    .ld_en    (ld_en)
  );

  mseq_next u_next (
    .q      (uaddr),
    .ld_en  (ld_en),
    .asel   (uw.asel),
    .nxt    (uw.nxt),
    .opcode (opcode),
    .q_nxt  (uaddr_nxt)
  );

  assign ld_acc = uw.ld_a;
  assign ld_pc  = uw.ld_pc;
  assign ld_mar = uw.ld_mar;
  assign ld_mdr = uw.ld_mdr;
  assign alu_fn = uw.fn;
  assign bsel   = uw.bsel;
  assign gate_a = uw.gate_a;
  assign mem_rd = uw.rd;
  assign mem_wr = uw.wt;
endmodule

// File: rtl/mseq_ctrl_chk.sv
module mseq_ctrl_chk
  import mseq_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            a_sign,
  input logic [OP_W-1:0] opcode,
  input uaddr_t          uaddr,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            ld_mdr,
  input logic            ld_pc
);
  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr == UA_STOP && !start) |=> (uaddr == UA_STOP));

  // R2
  stop_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr == UA_STOP && start) |=> (uaddr == UA_FETCH));

  // R3
  fetch_word_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr == UA_FETCH) |-> (mem_rd && ld_mdr && ld_pc));

  // R3
  fetch_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr == UA_FETCH) |=> (uaddr == UA_DECODE));

  // R4
  dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr == UA_DECODE) |=> (uaddr == dispatch_addr($past(opcode))));

  // R6
  jn_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr == dispatch_addr(OP_JN) && !a_sign) |=> (uaddr == UA_FETCH));

  // R6
  jn_take_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr == dispatch_addr(OP_JN) && a_sign) |=> (uaddr == (dispatch_addr(OP_JN) | uaddr_t'(1))));

  // R12
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

bind mseq_ctrl mseq_ctrl_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .a_sign (a_sign),
  .opcode (opcode),
  .uaddr  (uaddr),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .ld_mdr (ld_mdr),
  .ld_pc  (ld_pc)
);

// File: tb/mseq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mseq_ctrl_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, start, load_req;
  logic ld_acc, ld_pc, ld_mar, ld_mdr, gate_a, mem_rd, mem_wr;
  logic [3:0] alu_fn;
  logic [1:0] bsel;

  // datapath and memory model
  logic [11:0] acc, mdr, alu_q;
  logic [7:0]  pc, mar;
  logic [3:0]  ir;
  logic [11:0] mem [256];
  logic [11:0] img [256];
  logic [11:0] ref_mem [256];

  int n_chk = 0;
  int n_bad = 0;
  int overlap = 0;

  function automatic logic [11:0] alu_f(input logic [3:0] f, input logic [11:0] a, input logic [11:0] b);
    logic [11:0] bb;
    bb = f[3] ? ~b : b;
    case (f[1:0])
      2'b00:   return a & bb;
      2'b01:   return a | bb;
      2'b10:   return a + bb + {11'b0, f[2]};
      default: return 12'h000;
    endcase
  endfunction

  function automatic logic [11:0] b_pick(input logic [1:0] s, input logic [7:0] p, input logic [11:0] d);
    case (s)
      2'd0:    return 12'h000;
      2'd1:    return {4'h0, p};
      2'd2:    return {4'h0, d[7:0]};
      default: return d;
    endcase
  endfunction

  assign alu_q = alu_f(alu_fn, gate_a ? acc : 12'h000, b_pick(bsel, pc, mdr));

  mseq_ctrl dut_i (
    .clk (clk), .rst (rst), .start (start),
    .a_sign (acc[11]), .alu_zero (alu_q == 12'h000), .opcode (ir),
    .ld_acc (ld_acc), .ld_pc (ld_pc), .ld_mar (ld_mar), .ld_mdr (ld_mdr),
    .alu_fn (alu_fn), .bsel (bsel), .gate_a (gate_a),
    .mem_rd (mem_rd), .mem_wr (mem_wr)
  );

  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= img[i];
      acc <= '0; mdr <= '0; pc <= '0; mar <= '0; ir <= '0;
    end else begin
      if (ld_acc) acc <= alu_q;
      if (ld_pc)  pc  <= alu_q[7:0];
      if (ld_mar) mar <= alu_q[7:0];
      if (ld_mdr && mem_rd) mdr <= mem[mar];
      if (ld_mdr && ld_pc && mem_rd) ir <= mem[mar][11:8];
      if (mem_wr) mem[mar] <= acc;
    end
  end

  always @(negedge clk) if (!rst && mem_rd && mem_wr) overlap++;

  function automatic logic [12:0] outs();
    return {ld_acc, ld_pc, ld_mar, ld_mdr, alu_fn, bsel, gate_a, mem_rd, mem_wr};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 12'h000;
  endtask

  function automatic logic [11:0] ins(input logic [3:0] op, input logic [7:0] x);
    return {op, x};
  endfunction

  // architectural reference: cycles per instruction from the requirements
  task automatic ref_run(input int stop_pc, output int cyc, output logic [11:0] racc);
    int p;
    int steps;
    logic [11:0] a, w;
    logic [7:0] x;
    p = 0; a = '0; cyc = 0; steps = 0;
    for (int i = 0; i < 256; i++) ref_mem[i] = img[i];
    while (p != stop_pc && steps < 500) begin
      w = ref_mem[p]; x = w[7:0]; steps++;
      case (w[11:8])
        4'd0: begin p = x; cyc += 3; end
        4'd1: if (a[11]) begin p = x; cyc += 4; end else begin p = (p + 1) & 255; cyc += 3; end
        4'd2: if (a == 0) begin p = x; cyc += 4; end else begin p = (p + 1) & 255; cyc += 3; end
        4'd4: begin a = ref_mem[x]; p = (p + 1) & 255; cyc += 5; end
        4'd5: begin ref_mem[x] = a; p = (p + 1) & 255; cyc += 4; end
        4'd8: begin a = a & ref_mem[x]; p = (p + 1) & 255; cyc += 5; end
        4'd9: begin a = a | ref_mem[x]; p = (p + 1) & 255; cyc += 5; end
        4'd10: begin a = a + ref_mem[x]; p = (p + 1) & 255; cyc += 5; end
        4'd11: begin a = a - ref_mem[x]; p = (p + 1) & 255; cyc += 5; end
        default: begin p = (p + 1) & 255; cyc += 3; end
      endcase
    end
    racc = a;
  endtask

  task automatic run_prog(input int stop_pc, input string t_cyc, input string t_acc, input string t_mem);
    int ecyc, cyc, bad_i;
    logic [11:0] eacc;
    bit hit;
    ref_run(stop_pc, ecyc, eacc);
    @(negedge clk); rst = 1'b1; load_req = 1'b1; start = 1'b0;
    @(negedge clk); load_req = 1'b0;
    @(negedge clk); rst = 1'b0; start = 1'b1;
    cyc = 0; hit = 1'b0;
    for (int k = 0; k < 3000 && !hit; k++) begin
      @(negedge clk);
      cyc++;
      if (ld_pc && ld_mdr && mem_rd && mar == stop_pc[7:0]) hit = 1'b1;
    end
    check(hit && cyc == ecyc + 1, t_cyc, cyc, ecyc + 1);
    check(acc == eacc, t_acc, int'(acc), int'(eacc));
    bad_i = -1;
    for (int j = 128; j < 144; j++) if (bad_i < 0 && mem[j] != ref_mem[j]) bad_i = j;
    if (bad_i < 0) check(1'b1, t_mem, 0, 0);
    else check(1'b0, t_mem, int'(mem[bad_i]), int'(ref_mem[bad_i]));
  endtask

  task automatic gen_random();
    int n, kind, tgt;
    logic [7:0] d;
    clear_img();
    n = 8 + int'($urandom_range(0, 11));
    for (int i = 0; i < n; i++) begin
      kind = int'($urandom_range(0, 9));
      d = 8'h80 + 8'($urandom_range(0, 15));
      tgt = i + 1 + int'($urandom_range(0, n - i - 1));
      case (kind)
        0: img[i] = ins(4'd4, d);
        1: img[i] = ins(4'd5, d);
        2: img[i] = ins(4'd8, d);
        3: img[i] = ins(4'd9, d);
        4: img[i] = ins(4'd10, d);
        5: img[i] = ins(4'd11, d);
        6: img[i] = ins(4'd1, 8'(tgt));
        7: img[i] = ins(4'd2, 8'(tgt));
        8: img[i] = ins(4'd0, 8'(tgt));
        default: img[i] = ins(4'd12 + 4'($urandom_range(0, 3)), d);
      endcase
    end
    img[n] = ins(4'd0, 8'(n));
    for (int j = 128; j < 144; j++)
      img[j] = ($urandom_range(0, 3) == 0) ? 12'h000 : 12'($urandom_range(0, 4095));
    run_prog(n, "R5", "R9", "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit same;
    void'($urandom(32'd7741));
    rst = 1'b1; start = 1'b0; load_req = 1'b1;
    clear_img();
    repeat (3) @(negedge clk);
    load_req = 1'b0;
    // R1: idle word clears PC and MAR
    check(outs() == 13'b0_1_1_0_0010_00_0_0_0, "R1", int'(outs()), 13'b0_1_1_0_0010_00_0_0_0);
    rst = 1'b0;
    same = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (outs() != 13'b0_1_1_0_0010_00_0_0_0) same = 1'b0;
    end
    // R2: holds in idle with start low
    check(same, "R2", int'(outs()), 13'b0_1_1_0_0010_00_0_0_0);
    start = 1'b1;
    @(negedge clk);
    // R2 / R3: fetch word one cycle after start
    check(outs() == 13'b0_1_1_1_0110_01_0_1_0, "R3", int'(outs()), 13'b0_1_1_1_0110_01_0_1_0);
    @(negedge clk);
    check(outs() == 13'b0, "R3", int'(outs()), 0);

    // maximum of two values, both orders: R4, R6, R8, R9, R10
    for (int v = 0; v < 2; v++) begin
      clear_img();
      img[0] = ins(4'd4, 8'h80); img[1] = ins(4'd11, 8'h81);
      img[2] = ins(4'd1, 8'd5);  img[3] = ins(4'd4, 8'h80);
      img[4] = ins(4'd0, 8'd6);  img[5] = ins(4'd4, 8'h81);
      img[6] = ins(4'd5, 8'h82); img[7] = ins(4'd0, 8'd7);
      img[8'h80] = (v == 0) ? 12'h123 : 12'h045;
      img[8'h81] = (v == 0) ? 12'h045 : 12'h123;
      run_prog(7, "R6", "R4", "R10");
      check(mem[8'h82] == 12'h123, "R8", int'(mem[8'h82]), 12'h123);
    end

    // JN sign boundary 0x800 / 0x7FF: R6
    for (int v = 0; v < 2; v++) begin
      clear_img();
      img[0] = ins(4'd4, 8'h80); img[1] = ins(4'd1, 8'd3);
      img[2] = ins(4'd10, 8'h81); img[3] = ins(4'd5, 8'h82);
      img[4] = ins(4'd0, 8'd4);
      img[8'h80] = (v == 0) ? 12'h800 : 12'h7FF;
      img[8'h81] = 12'h001;
      run_prog(4, "R6", "R6", "R6");
    end

    // JZ zero / non-zero: R7
    for (int v = 0; v < 2; v++) begin
      clear_img();
      img[0] = ins(4'd4, 8'h80); img[1] = ins(4'd2, 8'd3);
      img[2] = ins(4'd10, 8'h81); img[3] = ins(4'd5, 8'h82);
      img[4] = ins(4'd0, 8'd4);
      img[8'h80] = (v == 0) ? 12'h000 : 12'h001;
      img[8'h81] = 12'h010;
      run_prog(4, "R7", "R7", "R7");
    end

    // reserved opcodes change nothing: R11
    clear_img();
    img[0] = ins(4'd4, 8'h80);
    img[1] = ins(4'd3, 8'h81);  img[2] = ins(4'd6, 8'h81);
    img[3] = ins(4'd7, 8'h81);  img[4] = ins(4'd12, 8'h81);
    img[5] = ins(4'd13, 8'h81); img[6] = ins(4'd14, 8'h81);
    img[7] = ins(4'd15, 8'h81); img[8] = ins(4'd5, 8'h82);
    img[9] = ins(4'd0, 8'd9);
    img[8'h80] = 12'h5A5; img[8'h81] = 12'hFFF;
    run_prog(9, "R11", "R11", "R11");

    // each ALU function: R9
    clear_img();
    img[0] = ins(4'd4, 8'h80); img[1] = ins(4'd8, 8'h81);  img[2] = ins(4'd5, 8'h82);
    img[3] = ins(4'd4, 8'h80); img[4] = ins(4'd9, 8'h81);  img[5] = ins(4'd5, 8'h83);
    img[6] = ins(4'd4, 8'h80); img[7] = ins(4'd10, 8'h81); img[8] = ins(4'd5, 8'h84);
    img[9] = ins(4'd4, 8'h80); img[10] = ins(4'd11, 8'h81); img[11] = ins(4'd5, 8'h85);
    img[12] = ins(4'd0, 8'd12);
    img[8'h80] = 12'hF0F; img[8'h81] = 12'h0FF;
    run_prog(12, "R9", "R9", "R9");
    check(mem[8'h85] == 12'hE10, "R9", int'(mem[8'h85]), 12'hE10);

    // seeded random programs: R5, R9, R10
    for (int t = 0; t < 24; t++) gen_random();

    // R12: read and write never together
    check(overlap == 0, "R12", overlap, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule